// File: doc/BRIEF.md
# Gated-Clock Sample Buffer with Self-Adjusting Flush Threshold

This block collects converter samples that arrive at irregular times, one for each edge of a gated sample clock, and hands them to a host-facing stream in bursts. Software starts a run by pulsing a start input together with the number of samples the run will produce. The block then holds a flush threshold. Whenever the buffer occupancy reaches that threshold, it raises a one-cycle interrupt and streams out a burst whose length is that threshold.

The threshold is never a fixed "buffer full" level. At start, and again after every burst, it is set to the smaller of the buffer depth and the number of samples the host is still owed. The last, shorter block of a run therefore drains as soon as its final sample lands, without extra clock edges or filler words. A mode input, captured at start, keeps the older behaviour in which the threshold stays at the full depth.

Top module: `acq_fifo_flush`

## Requirements
- R1: After reset, `done_o` is 1 and `m_valid_o`, `irq_o` and `overrun_o` are 0.
- R2: A start with a nonzero total clears `done_o` on the next cycle. The first burst is `min(total, DEPTH)` words long.
- R3: When occupancy reaches the threshold, `irq_o` is high for exactly one cycle. That cycle is the first one in which `m_valid_o` is high for the new burst.
- R4: Words leave in arrival order. `m_last_o` is 1 only on the final word of a burst, and the burst length equals the threshold captured when the burst began.
- R5: After each burst the threshold becomes `min(total - transferred, DEPTH)`, so a trailing partial block drains with no extra samples.
- R6: Samples that arrive during a burst are stored, including in a cycle where the buffer is full and a word is popped. They belong to the next burst, not the current one.
- R7: Once the transferred count reaches the total, `done_o` is set and input samples are ignored (no stream output, no interrupt) until the next start.
- R8: A sample that arrives while the buffer is full and no word is popped is dropped, and `overrun_o` is set. `overrun_o` stays set until the next start, which clears it.
- R9: A start with a total of zero is rejected: `done_o` stays 1 and later samples produce no output.
- R10: With the mode input at 1 during start, the threshold stays at DEPTH. A short run does not drain until DEPTH samples are stored.
- R11: While `m_valid_o` is 1 and `m_ready_i` is 0, `m_valid_o` and `m_data_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a new run (also aborts a run in progress) |
| total_i | input | 32 | Number of samples the run will deliver |
| legacy_i | input | 1 | 1 = threshold fixed at full depth, sampled at start |
| smp_valid_i | input | 1 | One-cycle strobe per gated sample edge |
| smp_data_i | input | DATA_W | Sample value |
| m_ready_i | input | 1 | Stream consumer ready |
| m_valid_o | output | 1 | Stream word valid |
| m_data_o | output | DATA_W | Stream word |
| m_last_o | output | 1 | Final word of the current burst |
| irq_o | output | 1 | One-cycle transfer request at the start of a burst |
| done_o | output | 1 | Run complete or idle |
| overrun_o | output | 1 | Sticky sample-lost flag |

## Verification
Two functions can act in the same cycle: a new sample being stored, and a word being popped into the stream, in particular when the buffer is exactly full. The bench provokes this by feeding samples every second cycle while a burst drains at one word per cycle, so arrivals land on pops at full occupancy. The result is judged on the stream: every word must appear once, in order, with `m_last_o` at the computed burst boundary and the expected number of interrupts. A separate case holds `m_ready_i` low so that the same arrival meets a full buffer without a pop; that sample must be dropped and raise `overrun_o`.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef logic [31:0] cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } acq_state_e;

    // Flush threshold for the remaining owed samples.
    function automatic cnt_t clip_mark(cnt_t owed, cnt_t depth, logic fixed_full);
        if (fixed_full)
            return depth;
        return (owed < depth) ? owed : depth;
    endfunction

endpackage

// File: rtl/acq_ring.sv
module acq_ring #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 16,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [FILL_W-1:0] fill,
    output logic              dropped
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              full, rd_ok, wr_ok;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (fill == FILL_W'(DEPTH));
    assign rd_ok   = rd_en && (fill != '0);
    assign wr_ok   = wr_en && (!full || rd_ok);
    assign dropped = wr_en && !wr_ok && !clear;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok && !clear)
            mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (rd_ok) rd_ptr <= bump(rd_ptr);
            case ({wr_ok, rd_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        int'(fill) <= DEPTH);

    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (fill != '0));

endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
    import acq_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cnt_t              total,
    input  logic              legacy,
    input  logic [FILL_W-1:0] fill,
    input  logic              pop,
    output logic              drain,
    output logic              last,
    output logic              irq,
    output logic              done
);
    localparam cnt_t DEPTH_C = cnt_t'(DEPTH);

    acq_state_e        state;
    logic [FILL_W-1:0] wm_q, burst_q, left_q;
    cnt_t              total_q, xfer_q, xfer_next;
    logic              legacy_q, irq_q;

    assign xfer_next = xfer_q + cnt_t'(burst_q);
    assign drain     = (state == ST_DRAIN);
    assign last      = drain && (left_q == FILL_W'(1));
    assign irq       = irq_q;
    assign done      = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            wm_q     <= '0;
            burst_q  <= '0;
            left_q   <= '0;
            total_q  <= '0;
            xfer_q   <= '0;
            legacy_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (start) begin
                if (total != '0) begin
                    state    <= ST_RUN;
                    total_q  <= total;
                    xfer_q   <= '0;
                    legacy_q <= legacy;
                    wm_q     <= FILL_W'(clip_mark(total, DEPTH_C, legacy));
                end else begin
                    state <= ST_IDLE;
                end
            end else begin
                case (state)
                    ST_RUN: begin
                        if (cnt_t'(fill) >= cnt_t'(wm_q)) begin
                            state   <= ST_DRAIN;
                            burst_q <= wm_q;
                            left_q  <= wm_q;
                            irq_q   <= 1'b1;
                        end
                    end
                    ST_DRAIN: begin
                        if (pop) begin
                            left_q <= left_q - 1'b1;
                            if (left_q == FILL_W'(1)) begin
                                xfer_q <= xfer_next;
                                if (xfer_next >= total_q) begin
                                    state <= ST_IDLE;
                                end else begin
                                    state <= ST_RUN;
                                    wm_q  <= FILL_W'(clip_mark(total_q - xfer_next,
                                                               DEPTH_C, legacy_q));
                                end
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assert_mark_range_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (wm_q != '0 && int'(wm_q) <= DEPTH));

    assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    assert_burst_backed_R4: assert property (@(posedge clk) disable iff (rst)
        drain |-> (cnt_t'(fill) >= cnt_t'(left_q)));

endmodule

// File: rtl/acq_fifo_flush.sv
module acq_fifo_flush
    import acq_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [31:0]       total_i,
    input  logic              legacy_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic              m_ready_i,
    output logic              m_valid_o,
    output logic [DATA_W-1:0] m_data_o,
    output logic              m_last_o,
    output logic              irq_o,
    output logic              done_o,
    output logic              overrun_o
);
    localparam int FILL_W = $clog2(DEPTH + 1);

    logic [FILL_W-1:0] fill;
    logic              drain, pop, wr_en, dropped, overrun_q;

    assign wr_en     = smp_valid_i && !done_o;
    assign pop       = drain && m_ready_i;
    assign m_valid_o = drain;
    assign overrun_o = overrun_q;

    acq_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FILL_W(FILL_W)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_i),
        .wr_en   (wr_en),
        .wr_data (smp_data_i),
        .rd_en   (pop),
        .rd_data (m_data_o),
        .fill    (fill),
        .dropped (dropped)
    );

    acq_ctrl #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .total  (cnt_t'(total_i)),
        .legacy (legacy_i),
        .fill   (fill),
        .pop    (pop),
        .drain  (drain),
        .last   (m_last_o),
        .irq    (irq_o),
        .done   (done_o)
    );

    always_ff @(posedge clk) begin
        if (rst || start_i)
            overrun_q <= 1'b0;
        else if (dropped)
            overrun_q <= 1'b1;
    end

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst || start_i)
        (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o)));

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && !start_i) |=> overrun_o);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!m_valid_o && !irq_o));

endmodule

// File: tb/sim_acq_fifo_flush.sv
module sim_acq_fifo_flush;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int DW         = 16;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        int total;
        int gap;
        int irqs;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{total: 1,  gap: 0, irqs: 1},
        '{total: 8,  gap: 0, irqs: 1},
        '{total: 13, gap: 1, irqs: 2},
        '{total: 16, gap: 1, irqs: 2},
        '{total: 21, gap: 3, irqs: 3},
        '{total: 5,  gap: 2, irqs: 1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [31:0]   total_i = '0;
    logic          legacy_i = 1'b0;
    logic          smp_valid_i = 1'b0;
    logic [DW-1:0] smp_data_i = '0;
    logic          m_ready_i = 1'b1;
    logic          m_valid_o, m_last_o, irq_o, done_o, overrun_o;
    logic [DW-1:0] m_data_o;

    int n_vec = 0, n_bad = 0, cycles = 0;
    int mon_en = 0, mon_total = 0, mon_legacy = 0;
    int mon_idx = 0, mon_pos = 0, mon_base = 0, irq_cnt = 0;
    int irq_seen = 0;

    acq_fifo_flush #(.DEPTH(DEPTH), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .total_i(total_i),
        .legacy_i(legacy_i), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
        .m_ready_i(m_ready_i), .m_valid_o(m_valid_o), .m_data_o(m_data_o),
        .m_last_o(m_last_o), .irq_o(irq_o), .done_o(done_o), .overrun_o(overrun_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Stream monitor: computes each burst length from the owed count.
    always @(negedge clk) begin
        if (irq_o) irq_seen++;
        if (mon_en != 0 && !rst) begin
            if (irq_o) begin
                irq_cnt++;
                chk(m_valid_o && mon_pos == 0, "R3", int'(m_valid_o), 1);
            end
            if (m_valid_o && m_ready_i) begin
                int blen;
                if (mon_legacy != 0)
                    blen = DEPTH;
                else
                    blen = (mon_total - mon_base < DEPTH) ? mon_total - mon_base : DEPTH;
                chk(m_data_o == DW'(mon_idx), "R4 R6 order", int'(m_data_o), mon_idx);
                chk(m_last_o == (mon_pos == blen - 1), (mon_base == 0) ? "R2" : "R5",
                    int'(m_last_o), int'(mon_pos == blen - 1));
                mon_idx++;
                if (mon_pos == blen - 1) begin
                    mon_pos = 0;
                    mon_base += blen;
                end else begin
                    mon_pos++;
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic kick(input int total, input bit legacy);
        start_i  = 1'b1;
        total_i  = 32'(total);
        legacy_i = legacy;
        step();
        start_i  = 1'b0;
        legacy_i = 1'b0;
    endtask

    task automatic feed(input int first, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            smp_valid_i = 1'b1;
            smp_data_i  = DW'(first + i);
            step();
            smp_valid_i = 1'b0;
            repeat (gap) step();
        end
    endtask

    task automatic arm_mon(input int total, input int legacy);
        mon_total = total; mon_legacy = legacy;
        mon_idx = 0; mon_pos = 0; mon_base = 0; irq_cnt = 0;
        mon_en = 1;
    endtask

    task automatic settle();
        for (int i = 0; i < 200; i++) begin
            if (done_o && !m_valid_o) break;
            step();
        end
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk(done_o == 1'b1, "R1 done", int'(done_o), 1);
        chk(!m_valid_o && !irq_o, "R1 stream", int'(m_valid_o), 0);
        chk(!overrun_o, "R1 overrun", int'(overrun_o), 0);

        // Vector walk: normal runs with varied totals and spacing
        for (int v = 0; v < 6; v++) begin
            arm_mon(VEC[v].total, 0);
            kick(VEC[v].total, 1'b0);
            chk(!done_o, "R2 start", int'(done_o), 0);
            feed(0, VEC[v].total, VEC[v].gap);
            settle();
            chk(done_o, "R7 done", int'(done_o), 1);
            chk(mon_idx == VEC[v].total, "R5 words", mon_idx, VEC[v].total);
            chk(irq_cnt == VEC[v].irqs, "R3 irqs", irq_cnt, VEC[v].irqs);
            chk(!overrun_o, "R6 no loss", int'(overrun_o), 0);
        end
        mon_en = 0;

        // R7: samples ignored once done
        irq_seen = 0;
        feed(50, 3, 1);
        repeat (4) step();
        chk(!m_valid_o && irq_seen == 0, "R7 ignored", irq_seen, 0);
        chk(done_o && !overrun_o, "R7 state", int'(done_o), 1);

        // R9: zero total rejected
        kick(0, 1'b0);
        chk(done_o, "R9 done", int'(done_o), 1);
        feed(60, DEPTH + 2, 0);
        repeat (4) step();
        chk(!m_valid_o && irq_seen == 0, "R9 no output", int'(m_valid_o), 0);
        chk(!overrun_o, "R9 overrun", int'(overrun_o), 0);

        // R10: fixed full-depth threshold
        arm_mon(5, 1);
        kick(5, 1'b1);
        feed(0, 5, 1);
        repeat (20) step();
        chk(!m_valid_o && irq_cnt == 0, "R10 held", int'(m_valid_o), 0);
        chk(!done_o, "R10 not done", int'(done_o), 0);
        feed(5, 3, 1);
        settle();
        chk(mon_idx == DEPTH, "R10 burst", mon_idx, DEPTH);
        chk(irq_cnt == 1 && done_o, "R10 done", irq_cnt, 1);
        mon_en = 0;

        // R8 / R11: stalled stream, overflow
        m_ready_i = 1'b0;
        kick(20, 1'b0);
        feed(100, DEPTH + 2, 0);
        step();
        chk(overrun_o, "R8 set", int'(overrun_o), 1);
        chk(m_valid_o && m_data_o == DW'(100), "R11 head", int'(m_data_o), 100);
        repeat (3) step();
        chk(m_valid_o && m_data_o == DW'(100), "R11 hold", int'(m_data_o), 100);
        chk(overrun_o, "R8 sticky", int'(overrun_o), 1);
        m_ready_i = 1'b1;
        kick(3, 1'b0);
        chk(!overrun_o && !m_valid_o, "R8 cleared", int'(overrun_o), 0);
        arm_mon(3, 0);
        feed(0, 3, 0);
        settle();
        chk(mon_idx == 3 && done_o, "R5 restart", mon_idx, 3);
        mon_en = 0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule